// File: doc/BRIEF.md
# Scalable Vector Access Control Unit

This unit decides, for the current exception level, whether scalable-vector instructions and the vector-length control registers may be used. When they may not, it gives the exception level that the trap is taken to. A fixed priority chain evaluates the inputs in this order: the vector enable field of the access control word, then the FP enable field of the same word, then the level-2 trap bits, then the level-3 enable and trap bits. If none of these checks fires, the result is zero and access is allowed.

The unit also holds three four-bit length registers, one each for levels 1, 2 and 3, behind a simple write and read port. From them it derives the effective length value that the instruction decoder uses. That value starts from the register of the current level. Levels 0 and 1 share the level-1 register. The value is then reduced by the register of each higher level that is present. It is forced to zero when vector use traps while FP use is allowed. The trap result for FP use is an input that comes from logic outside this unit.

The unit has no state machine. The priority chain and the clamp are combinational, and the only storage is the bank of length registers. The registers have two states: reset, where all three hold 0, and loaded. A register moves from reset to loaded, or is updated again, only when a write is accepted.

Top module: `vxs_access_ctrl`

## Requirements
- R1: The vector enable field is `ctrl_word[17:16]`. Value 3 traps nothing. Value 1 traps only at level 0. Values 0 and 2 trap at levels 0 and 1. A low-level trap reports `trap_lvl` = 1.
- R2: If the vector field does not trap, the FP enable field `ctrl_word[21:20]` is checked next, with the same encoding. The two fields are checked before the level-2 and level-3 bits, so a trap from either field wins over both.
- R3: A trap raised by either field goes to level 3 instead of level 1 when `secure`=1 and `l3_is_64`=0.
- R4: If neither field traps, and `cur_lvl` ≤ 2, and `l2_fp_trap` or `l2_vec_trap` is set, and `secure`=0, then `trap_lvl` = 2.
- R5: If no earlier check fires, `trap_lvl` = 3 when `l3_vec_en`=0 or `l3_fp_trap`=1. Otherwise `trap_lvl` = 0 (access allowed). The encoding is 0 = OK and 1, 2, 3 = trap to that level.
- R6: Only bits [3:0] of written data are stored. `rd_data` returns the stored value zero-extended to 64 bits. `rd_lvl`=0 reads zero.
- R7: When `has_l2`=0, the level-2 register reads as zero and writes to it are ignored. The same holds for level 3 when `has_l3`=0.
- R8: A write to register `wr_lvl` is accepted only if all of the following hold: `trap_lvl`=0, `wr_lvl`≠0, and `cur_lvl` ≥ `wr_lvl`. Otherwise the stored value is unchanged.
- R9: `eff_len` = 0 when `trap_lvl`≠0 and `fp_trap_lvl`=0.
- R10: In all other cases, `eff_len` starts from the register of the current level. Levels 0 and 1 both use the level-1 register.
- R11: When `cur_lvl` < 2 and `has_l2`=1, `eff_len` is lowered to the level-2 register if that is smaller. When `cur_lvl` < 3 and `has_l3`=1, it is likewise lowered to the level-3 register.
- R12: After reset, all three length registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Access control word; vector field [17:16], FP field [21:20] |
| l2_fp_trap | input | 1 | Level-2 FP trap bit |
| l2_vec_trap | input | 1 | Level-2 vector trap bit |
| l3_vec_en | input | 1 | Level-3 vector enable bit |
| l3_fp_trap | input | 1 | Level-3 FP trap bit |
| cur_lvl | input | 2 | Current exception level |
| secure | input | 1 | Core is in secure state |
| l3_is_64 | input | 1 | Level 3 runs in 64-bit state |
| has_l2 | input | 1 | Level 2 implemented |
| has_l3 | input | 1 | Level 3 implemented |
| fp_trap_lvl | input | 2 | FP trap result from outside (0 = FP allowed) |
| wr_en | input | 1 | Length register write strobe |
| wr_lvl | input | 2 | Level of register written |
| wr_data | input | 64 | Write data |
| rd_lvl | input | 2 | Level of register read |
| trap_lvl | output | 2 | Trap destination, 0 = allowed |
| rd_data | output | 64 | Read data |
| eff_len | output | 4 | Effective length field for the decoder |

## Verification
On every cycle, the assertions check four things. A level-3 disable always gives a non-zero trap. At level 3, only 0 or 3 can be reported. An accepted level-1 write stores exactly the low four bits. A trapped cycle never changes the level-1 register. They also check the level-2 clamp bound and the zero read of an absent level-2 register. The order of the priority chain can only be shown by the bench's scenarios, which set several trap sources at once. The same applies to the secure redirect to level 3, the privilege rule on writes, the effective-length zeroing and the selection of the base register at each level.

// File: rtl/vxs_pkg.sv
package vxs_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_OK = 2'd0;
    localparam lvl_t LVL_1  = 2'd1;
    localparam lvl_t LVL_2  = 2'd2;
    localparam lvl_t LVL_3  = 2'd3;

    // Decode of a two-bit enable field: 3 none, 1 level 0 only, 0/2 levels 0 and 1
    function automatic lvl_t field_trap(input logic [1:0] fld, input lvl_t el, input lvl_t low);
        lvl_t r;
        r = LVL_OK;
        case (fld)
            2'd3:    r = LVL_OK;
            2'd1:    r = (el == 2'd0) ? low : LVL_OK;
            default: r = (el <= 2'd1) ? low : LVL_OK;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vxs_trap_chain.sv
module vxs_trap_chain
    import vxs_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int VEC_LSB = 16,
    parameter int FP_LSB  = 20
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              l2_fp_trap,
    input  logic              l2_vec_trap,
    input  logic              l3_vec_en,
    input  logic              l3_fp_trap,
    input  lvl_t              cur_lvl,
    input  logic              secure,
    input  logic              l3_is_64,
    output lvl_t              trap_lvl
);

    logic [1:0] vec_fld;
    logic [1:0] fp_fld;
    lvl_t       low_dst;
    lvl_t       vec_res;
    lvl_t       fp_res;

    assign vec_fld = ctrl_word[VEC_LSB +: 2];
    assign fp_fld  = ctrl_word[FP_LSB +: 2];
    assign low_dst = (secure && !l3_is_64) ? LVL_3 : LVL_1;
    assign vec_res = field_trap(vec_fld, cur_lvl, low_dst);
    assign fp_res  = field_trap(fp_fld, cur_lvl, low_dst);

    always_comb begin
        if (vec_res != LVL_OK) begin
            trap_lvl = vec_res;
        end else if (fp_res != LVL_OK) begin
            trap_lvl = fp_res;
        end else if ((cur_lvl <= 2'd2) && (l2_fp_trap || l2_vec_trap) && !secure) begin
            trap_lvl = LVL_2;
        end else if (!l3_vec_en || l3_fp_trap) begin
            trap_lvl = LVL_3;
        end else begin
            trap_lvl = LVL_OK;
        end
    end

endmodule

// File: rtl/vxs_len_bank.sv
module vxs_len_bank
    import vxs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4,
    parameter int N_LVL  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        has_l2,
    input  logic                        has_l3,
    input  logic                        wr_ok,
    input  lvl_t                        wr_lvl,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [N_LVL:1][LEN_W-1:0]   len_rd
);

    genvar g;
    generate
        for (g = 1; g <= N_LVL; g++) begin : g_lvl
            logic             present;
            logic [LEN_W-1:0] len_q;

            if (g == 2) begin : g_p2
                assign present = has_l2;
            end else if (g == 3) begin : g_p3
                assign present = has_l3;
            end else begin : g_p1
                assign present = 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    len_q <= '0;
                end else if (wr_ok && present && (wr_lvl == lvl_t'(g))) begin
                    len_q <= wr_data[LEN_W-1:0];
                end
            end

            assign len_rd[g] = present ? len_q : '0;
        end
    endgenerate

endmodule

// File: rtl/vxs_len_clamp.sv
module vxs_len_clamp
    import vxs_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic [3:1][LEN_W-1:0] len_rd,
    input  lvl_t                  cur_lvl,
    input  logic                  has_l2,
    input  logic                  has_l3,
    input  logic                  force_zero,
    output logic [LEN_W-1:0]      eff_len
);

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] after_l2;
    logic [LEN_W-1:0] after_l3;

    always_comb begin
        base = (cur_lvl <= 2'd1) ? len_rd[1] : len_rd[cur_lvl];
        after_l2 = base;
        if ((cur_lvl < 2'd2) && has_l2 && (len_rd[2] < base)) begin
            after_l2 = len_rd[2];
        end
        after_l3 = after_l2;
        if ((cur_lvl < 2'd3) && has_l3 && (len_rd[3] < after_l2)) begin
            after_l3 = len_rd[3];
        end
        eff_len = force_zero ? '0 : after_l3;
    end

endmodule

// File: rtl/vxs_access_ctrl.sv
module vxs_access_ctrl
    import vxs_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 4,
    parameter int VEC_LSB = 16,
    parameter int FP_LSB  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              l2_fp_trap,
    input  logic              l2_vec_trap,
    input  logic              l3_vec_en,
    input  logic              l3_fp_trap,
    input  logic [1:0]        cur_lvl,
    input  logic              secure,
    input  logic              l3_is_64,
    input  logic              has_l2,
    input  logic              has_l3,
    input  logic [1:0]        fp_trap_lvl,
    input  logic              wr_en,
    input  logic [1:0]        wr_lvl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_lvl,
    output logic [1:0]        trap_lvl,
    output logic [DATA_W-1:0] rd_data,
    output logic [LEN_W-1:0]  eff_len
);

    localparam int N_LVL = 3;
    localparam int PAD_W = DATA_W - LEN_W;

    logic                      wr_ok;
    logic                      force_zero;
    logic [N_LVL:1][LEN_W-1:0] len_rd;
    logic [LEN_W-1:0]          len_l1;
    logic [LEN_W-1:0]          len_l2;
    logic [LEN_W-1:0]          len_l3;
    logic [LEN_W-1:0]          rd_len;

    vxs_trap_chain #(
        .CTRL_W  (CTRL_W),
        .VEC_LSB (VEC_LSB),
        .FP_LSB  (FP_LSB)
    ) i_chain (
        .ctrl_word   (ctrl_word),
        .l2_fp_trap  (l2_fp_trap),
        .l2_vec_trap (l2_vec_trap),
        .l3_vec_en   (l3_vec_en),
        .l3_fp_trap  (l3_fp_trap),
        .cur_lvl     (cur_lvl),
        .secure      (secure),
        .l3_is_64    (l3_is_64),
        .trap_lvl    (trap_lvl)
    );

    assign wr_ok = wr_en && (trap_lvl == LVL_OK) && (wr_lvl != 2'd0) && (cur_lvl >= wr_lvl);

    vxs_len_bank #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .N_LVL  (N_LVL)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .has_l2  (has_l2),
        .has_l3  (has_l3),
        .wr_ok   (wr_ok),
        .wr_lvl  (wr_lvl),
        .wr_data (wr_data),
        .len_rd  (len_rd)
    );

    assign len_l1 = len_rd[1];
    assign len_l2 = len_rd[2];
    assign len_l3 = len_rd[3];

    assign rd_len  = (rd_lvl == 2'd0) ? '0 : len_rd[rd_lvl];
    assign rd_data = {{PAD_W{1'b0}}, rd_len};

    assign force_zero = (trap_lvl != LVL_OK) && (fp_trap_lvl == LVL_OK);

    vxs_len_clamp #(
        .LEN_W (LEN_W)
    ) i_clamp (
        .len_rd     (len_rd),
        .cur_lvl    (cur_lvl),
        .has_l2     (has_l2),
        .has_l3     (has_l3),
        .force_zero (force_zero),
        .eff_len    (eff_len)
    );

endmodule

// File: rtl/vxs_access_ctrl_chk.sv
module vxs_access_ctrl_chk #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cur_lvl,
    input logic              l3_vec_en,
    input logic              has_l2,
    input logic              wr_en,
    input logic [1:0]        wr_lvl,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        rd_lvl,
    input logic [1:0]        trap_lvl,
    input logic [DATA_W-1:0] rd_data,
    input logic [LEN_W-1:0]  eff_len,
    input logic [LEN_W-1:0]  len_l1,
    input logic [LEN_W-1:0]  len_l2
);

    // R5
    l3_disable_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l3_vec_en |-> (trap_lvl != 2'd0));

    // R5
    top_level_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl == 2'd3) |-> ((trap_lvl == 2'd0) || (trap_lvl == 2'd3)));

    // R6
    write_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_lvl == 2'd1) && (trap_lvl == 2'd0) && (cur_lvl != 2'd0))
        |=> (len_l1 == $past(wr_data[LEN_W-1:0])));

    // R8
    trapped_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_lvl != 2'd0) |=> $stable(len_l1));

    // R7
    absent_l2_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_l2 && (rd_lvl == 2'd2)) |-> (rd_data == '0));

    // R11
    l2_clamp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_lvl < 2'd2) && has_l2) |-> (eff_len <= len_l2));

endmodule

bind vxs_access_ctrl vxs_access_ctrl_chk #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_lvl   (cur_lvl),
    .l3_vec_en (l3_vec_en),
    .has_l2    (has_l2),
    .wr_en     (wr_en),
    .wr_lvl    (wr_lvl),
    .wr_data   (wr_data),
    .rd_lvl    (rd_lvl),
    .trap_lvl  (trap_lvl),
    .rd_data   (rd_data),
    .eff_len   (eff_len),
    .len_l1    (len_l1),
    .len_l2    (len_l2)
);

// File: tb/test_vxs_access_ctrl.sv
module test_vxs_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        l2_fp_trap = 1'b0;
    logic        l2_vec_trap = 1'b0;
    logic        l3_vec_en = 1'b1;
    logic        l3_fp_trap = 1'b0;
    logic [1:0]  cur_lvl = 2'd3;
    logic        secure = 1'b0;
    logic        l3_is_64 = 1'b1;
    logic        has_l2 = 1'b1;
    logic        has_l3 = 1'b1;
    logic [1:0]  fp_trap_lvl = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_lvl = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_lvl = 2'd0;
    logic [1:0]  trap_lvl;
    logic [63:0] rd_data;
    logic [3:0]  eff_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [1:0]  trap;
        logic [63:0] rd;
        logic [3:0]  eff;
    } exp_t;

    exp_t sb_q[$];
    logic [3:0] m_len [1:3];

    always #5 clk = ~clk;

    vxs_access_ctrl i_vxs_access_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .l2_fp_trap(l2_fp_trap), .l2_vec_trap(l2_vec_trap),
        .l3_vec_en(l3_vec_en), .l3_fp_trap(l3_fp_trap),
        .cur_lvl(cur_lvl), .secure(secure), .l3_is_64(l3_is_64),
        .has_l2(has_l2), .has_l3(has_l3), .fp_trap_lvl(fp_trap_lvl),
        .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_data(wr_data), .rd_lvl(rd_lvl),
        .trap_lvl(trap_lvl), .rd_data(rd_data), .eff_len(eff_len)
    );

    // reference model built from the requirements
    function automatic logic [1:0] m_field(logic [1:0] f, logic [1:0] el, logic [1:0] low);
        if (f == 2'd3) return 2'd0;
        if (f == 2'd1) return (el == 2'd0) ? low : 2'd0;
        return (el <= 2'd1) ? low : 2'd0;
    endfunction

    function automatic logic [1:0] m_trap();
        logic [1:0] low;
        logic [1:0] t;
        low = (secure && !l3_is_64) ? 2'd3 : 2'd1;
        t = m_field(ctrl_word[17:16], cur_lvl, low);
        if (t != 2'd0) return t;
        t = m_field(ctrl_word[21:20], cur_lvl, low);
        if (t != 2'd0) return t;
        if ((cur_lvl <= 2'd2) && (l2_fp_trap || l2_vec_trap) && !secure) return 2'd2;
        if (!l3_vec_en || l3_fp_trap) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [3:0] m_read(logic [1:0] l);
        if (l == 2'd0) return 4'd0;
        if (l == 2'd2 && !has_l2) return 4'd0;
        if (l == 2'd3 && !has_l3) return 4'd0;
        return m_len[l];
    endfunction

    function automatic logic [3:0] m_eff();
        logic [3:0] v;
        if ((m_trap() != 2'd0) && (fp_trap_lvl == 2'd0)) return 4'd0;
        v = m_read((cur_lvl <= 2'd1) ? 2'd1 : cur_lvl);
        if ((cur_lvl < 2'd2) && has_l2 && (m_read(2'd2) < v)) v = m_read(2'd2);
        if ((cur_lvl < 2'd3) && has_l3 && (m_read(2'd3) < v)) v = m_read(2'd3);
        return v;
    endfunction

    task automatic set_in(logic [1:0] vf, logic [1:0] ff, logic [1:0] cl,
                          logic sec, logic l364, logic l2f, logic l2v,
                          logic l3e, logic l3f, logic [1:0] fpl);
        ctrl_word = 32'h0;
        ctrl_word[17:16] = vf;
        ctrl_word[21:20] = ff;
        cur_lvl = cl; secure = sec; l3_is_64 = l364;
        l2_fp_trap = l2f; l2_vec_trap = l2v;
        l3_vec_en = l3e; l3_fp_trap = l3f; fp_trap_lvl = fpl;
    endtask

    // driver: push expectation, monitor compares at the following negedge
    task automatic check(string tag, logic [1:0] rl);
        exp_t e;
        @(posedge clk);
        #1;
        rd_lvl = rl;
        e.tag = tag;
        e.trap = m_trap();
        e.rd = {60'd0, m_read(rl)};
        e.eff = m_eff();
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic do_write(logic [1:0] l, logic [63:0] d);
        logic acc;
        @(posedge clk);
        #1;
        wr_lvl = l; wr_data = d; wr_en = 1'b1;
        acc = (m_trap() == 2'd0) && (l != 2'd0) && (cur_lvl >= l) &&
              !(l == 2'd2 && !has_l2) && !(l == 2'd3 && !has_l3);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (acc) m_len[l] = d[3:0];
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks += 3;
            if (trap_lvl !== e.trap) begin
                failures++;
                $display("FAIL %s trap_lvl actual=%0d expected=%0d", e.tag, trap_lvl, e.trap);
            end
            if (rd_data !== e.rd) begin
                failures++;
                $display("FAIL %s rd_data actual=%0h expected=%0h", e.tag, rd_data, e.rd);
            end
            if (eff_len !== e.eff) begin
                failures++;
                $display("FAIL %s eff_len actual=%0d expected=%0d", e.tag, eff_len, e.eff);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_len[1] = 4'd0; m_len[2] = 4'd0; m_len[3] = 4'd0;
        set_in(2'd3, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        check("R12", 2'd1);
        check("R12", 2'd2);
        check("R12", 2'd3);

        // R6 only low four bits kept
        do_write(2'd1, 64'hFFFF_FFFF_FFFF_FFF9);
        do_write(2'd2, 64'hABCD_0000_1234_567C);
        do_write(2'd3, 64'h8000_0000_0000_0017);
        check("R6", 2'd1);
        check("R6", 2'd2);
        check("R6", 2'd3);
        check("R6", 2'd0);

        // R1 vector field encodings
        set_in(2'd1, 2'd3, 2'd0, 0, 1, 0, 0, 1, 0, 2'd1); check("R1", 2'd1);
        set_in(2'd1, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd1); check("R1", 2'd1);
        set_in(2'd0, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd1); check("R1", 2'd1);
        set_in(2'd2, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd1); check("R1", 2'd1);
        set_in(2'd2, 2'd3, 2'd2, 0, 1, 0, 0, 1, 0, 2'd1); check("R1", 2'd2);

        // R2 FP field and precedence
        set_in(2'd3, 2'd1, 2'd0, 0, 1, 0, 0, 1, 0, 2'd1); check("R2", 2'd1);
        set_in(2'd3, 2'd0, 2'd1, 0, 1, 0, 0, 1, 0, 2'd1); check("R2", 2'd1);
        set_in(2'd1, 2'd2, 2'd1, 0, 1, 0, 0, 1, 0, 2'd1); check("R2", 2'd1);
        set_in(2'd0, 2'd3, 2'd1, 0, 1, 0, 1, 0, 0, 2'd1); check("R2", 2'd1);

        // R3 secure redirect
        set_in(2'd0, 2'd3, 2'd1, 1, 0, 0, 0, 1, 0, 2'd1); check("R3", 2'd1);
        set_in(2'd0, 2'd3, 2'd1, 1, 1, 0, 0, 1, 0, 2'd1); check("R3", 2'd1);
        set_in(2'd3, 2'd0, 2'd0, 1, 0, 0, 0, 1, 0, 2'd1); check("R3", 2'd1);

        // R4 level-2 trap bits
        set_in(2'd3, 2'd3, 2'd2, 0, 1, 1, 0, 1, 0, 2'd1); check("R4", 2'd2);
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 1, 1, 0, 2'd1); check("R4", 2'd2);
        set_in(2'd3, 2'd3, 2'd1, 1, 1, 0, 1, 1, 0, 2'd1); check("R4", 2'd2);
        set_in(2'd3, 2'd3, 2'd3, 0, 1, 1, 0, 1, 0, 2'd1); check("R4", 2'd2);

        // R5 level-3 bits and the allowed case
        set_in(2'd0, 2'd0, 2'd3, 0, 1, 0, 0, 0, 0, 2'd1); check("R5", 2'd3);
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 1, 1, 2'd1); check("R5", 2'd3);
        set_in(2'd0, 2'd0, 2'd3, 0, 1, 0, 0, 1, 0, 2'd0); check("R5", 2'd3);
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0); check("R5", 2'd1);

        // R9 zeroed length when vector traps and FP does not
        set_in(2'd0, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0); check("R9", 2'd1);
        set_in(2'd0, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd1); check("R9", 2'd1);

        // R10 base register per level, R11 clamping
        set_in(2'd3, 2'd3, 2'd0, 0, 1, 0, 0, 1, 0, 2'd0); check("R10", 2'd1);
        set_in(2'd3, 2'd3, 2'd2, 0, 1, 0, 0, 1, 0, 2'd0); check("R10", 2'd2);
        set_in(2'd3, 2'd3, 2'd3, 0, 1, 0, 0, 1, 0, 2'd0); check("R10", 2'd3);
        set_in(2'd3, 2'd3, 2'd3, 0, 1, 0, 0, 1, 0, 2'd0);
        do_write(2'd3, 64'h0F);
        do_write(2'd1, 64'h0D);
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0); check("R11", 2'd1);
        set_in(2'd3, 2'd3, 2'd2, 0, 1, 0, 0, 1, 0, 2'd0); check("R11", 2'd3);
        has_l2 = 1'b0;
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0); check("R11", 2'd1);
        has_l2 = 1'b1; has_l3 = 1'b0;
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0); check("R11", 2'd3);
        has_l3 = 1'b1;

        // R8 write rules
        set_in(2'd0, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0);
        do_write(2'd1, 64'h3);
        check("R8", 2'd1);
        set_in(2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 1, 0, 2'd0);
        do_write(2'd2, 64'h1);
        check("R8", 2'd2);
        do_write(2'd1, 64'h2);
        check("R8", 2'd1);
        do_write(2'd0, 64'h5);
        check("R8", 2'd0);

        // R7 absent levels
        has_l2 = 1'b0;
        set_in(2'd3, 2'd3, 2'd3, 0, 1, 0, 0, 1, 0, 2'd0);
        check("R7", 2'd2);
        do_write(2'd2, 64'h4);
        check("R7", 2'd2);
        has_l2 = 1'b1;
        check("R7", 2'd2);
        has_l3 = 1'b0;
        do_write(2'd3, 64'h6);
        check("R7", 2'd3);
        has_l3 = 1'b1;
        check("R7", 2'd3);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule